// File: doc/BRIEF.md
# Pin Port Control Register Block

This block is the register side of a 16-pin digital I/O port. A processor-side bus performs single-cycle reads and writes. Each pin has four settings: a 2-bit direction mode, a push-pull or open-drain select bit, a 2-bit drive-speed code and a 2-bit pull selection. The block turns these settings into per-pin pad controls: drive value, drive enable, open-drain enable, pull-up, pull-down and speed.

Software can change the driven levels in two ways. It can write the whole output word at once. It can also use a write-only set/clear word, which raises or lowers chosen pins in one write with no read-modify-write. Pin levels come back through a two-flop synchronizer into a read-only input word. Because that word samples the pad itself, an open-drain pin that software has released shows the level the wire actually has. That level may differ from the drive value.

The bus accepts a transfer every cycle and never stalls. There is no back-pressure: a write with `wr_en` high takes effect at that clock edge, and `rd_data` follows `addr` in the same cycle. Word addresses: 0 mode, 1 output type, 2 speed, 3 pull, 4 output data, 5 input data, 6 set/clear, 7 unused (reads zero).

Top module: `gpio_port_regs`

## Requirements
- R1: After reset every configuration word and the output word are zero. As a result, all pins are floating inputs, with `pad_oe`, `pad_od`, `pad_pu`, `pad_pd`, `pad_out` and `pad_speed` all zero.
- R2: A write to address 6 with bit n (0..15) at 1 drives `pad_out[n]` high from the next cycle. Bits written as 0 leave their pin unchanged.
- R3: A write to address 6 with bit 16+n at 1 (and bit n at 0) drives `pad_out[n]` low from the next cycle.
- R4: If a single write to address 6 has both bit n and bit 16+n at 1, pin n goes high: set takes priority over clear.
- R5: Address 6 always reads as zero and holds no state. A write to address 4 loads `pad_out` directly, and address 4 reads back the driven value. No other write changes `pad_out`.
- R6: Address 5 returns each pin's level as it was two clock edges earlier, after a two-flop synchronizer. It shows the pad level even where this differs from the driven value (an open-drain pin released high but held low outside). Writes to address 5 are ignored.
- R7: The mode field of pin n sits at bits 2n+1:2n of address 0, with the codes 00 input, 01 output, 10 alternate and 11 analog. `pad_oe[n]` is 1 only for code 01.
- R8: Bit n of address 1 selects open-drain (1) or push-pull (0). `pad_od[n]` is 1 only when this bit is 1 and pin n is in output mode.
- R9: The pull field of pin n sits at bits 2n+1:2n of address 3. Code 01 raises `pad_pu[n]`, code 10 raises `pad_pd[n]`, and codes 00 and 11 raise neither.
- R10: The speed field of pin n sits at bits 2n+1:2n of address 2, with the codes 0 low, 1 medium, 2 high and 3 very high. It appears unchanged on `pad_speed[2n+1:2n]`.
- R11: Addresses 0 to 3 read back the value last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 3 | Word address |
| wr_en | input | 1 | Write strobe, one transfer per cycle |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for `addr`, combinational |
| pad_in | input | 16 | Raw pin levels from the pads |
| pad_out | output | 16 | Drive value per pin |
| pad_oe | output | 16 | Drive enable per pin |
| pad_od | output | 16 | Open-drain enable per pin |
| pad_pu | output | 16 | Pull-up enable per pin |
| pad_pd | output | 16 | Pull-down enable per pin |
| pad_speed | output | 32 | Speed code per pin, 2 bits each |

## Verification
The bench builds the block with its defaults: `NUM_PINS` = 16, `SYNC_STAGES` = 2 and `DATA_W` = 32. With 16 pins, the set/clear word fills all 32 data bits. This lets the tests reach pin 15 together with the clear bit at bit 31, and lets a single write carry conflicting set and clear bits on every pin at once. With two synchronizer stages, the bench can show that a pin change is still invisible one cycle later and visible two cycles later.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int REG_AW = 3;

  typedef enum logic [REG_AW-1:0] {
    A_MODE   = 3'd0,
    A_OTYPE  = 3'd1,
    A_SPEED  = 3'd2,
    A_PULL   = 3'd3,
    A_OUT    = 3'd4,
    A_IN     = 3'd5,
    A_SETCLR = 3'd6
  } reg_sel_e;

  typedef enum logic [1:0] {
    MODE_INPUT  = 2'b00,
    MODE_OUTPUT = 2'b01,
    MODE_ALT    = 2'b10,
    MODE_ANALOG = 2'b11
  } pin_mode_e;

  localparam logic [1:0] PULL_CODE_UP   = 2'b01;
  localparam logic [1:0] PULL_CODE_DOWN = 2'b10;
endpackage

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
  import gpio_pkg::*;
#(
  parameter int NUM_PINS = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [REG_AW-1:0]     addr,
  input  logic [2*NUM_PINS-1:0] wr_field,
  output logic [2*NUM_PINS-1:0] mode_q,
  output logic [NUM_PINS-1:0]   otype_q,
  output logic [2*NUM_PINS-1:0] speed_q,
  output logic [2*NUM_PINS-1:0] pull_q
);
  // Reset values give a floating input with slow drive on every pin.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      otype_q <= '0;
      speed_q <= '0;
      pull_q  <= '0;
    end else if (wr_en) begin
      case (addr)
        A_MODE:  mode_q  <= wr_field;
        A_OTYPE: otype_q <= wr_field[NUM_PINS-1:0];
        A_SPEED: speed_q <= wr_field;
        A_PULL:  pull_q  <= wr_field;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/gpio_out_reg.sv
module gpio_out_reg
  import gpio_pkg::*;
#(
  parameter int NUM_PINS = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [REG_AW-1:0]     addr,
  input  logic [2*NUM_PINS-1:0] wr_field,
  output logic [NUM_PINS-1:0]   out_q
);
  logic [NUM_PINS-1:0] set_mask, clr_mask, out_d;

  assign set_mask = wr_field[NUM_PINS-1:0];
  assign clr_mask = wr_field[2*NUM_PINS-1:NUM_PINS];

  // Set/clear write: clear first, then set, so a set bit overrides its clear bit.
  always_comb begin
    out_d = out_q;
    if (wr_en) begin
      if (addr == A_OUT)
        out_d = set_mask;
      else if (addr == A_SETCLR)
        out_d = (out_q & ~clr_mask) | set_mask;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= '0;
    else        out_q <= out_d;
  end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int NUM_PINS    = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] raw_in,
  output logic [NUM_PINS-1:0] sync_out
);
  logic [NUM_PINS-1:0] stage_q [SYNC_STAGES];

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= raw_in;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign sync_out = stage_q[SYNC_STAGES-1];
endmodule

// File: rtl/gpio_pin_ctrl.sv
module gpio_pin_ctrl
  import gpio_pkg::*;
#(
  parameter int NUM_PINS = 16
) (
  input  logic [2*NUM_PINS-1:0] mode_q,
  input  logic [NUM_PINS-1:0]   otype_q,
  input  logic [2*NUM_PINS-1:0] pull_q,
  output logic [NUM_PINS-1:0]   oe,
  output logic [NUM_PINS-1:0]   od,
  output logic [NUM_PINS-1:0]   pu,
  output logic [NUM_PINS-1:0]   pd
);
  for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
    pin_mode_e   mode_n;
    logic [1:0]  pull_n;
    assign mode_n = pin_mode_e'(mode_q[2*n +: 2]);
    assign pull_n = pull_q[2*n +: 2];
    assign oe[n]  = (mode_n == MODE_OUTPUT);
    assign od[n]  = (mode_n == MODE_OUTPUT) && otype_q[n];
    assign pu[n]  = (pull_n == PULL_CODE_UP);
    assign pd[n]  = (pull_n == PULL_CODE_DOWN);
  end
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_pkg::*;
#(
  parameter int NUM_PINS    = 16,
  parameter int SYNC_STAGES = 2,
  parameter int DATA_W      = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [REG_AW-1:0]     addr,
  input  logic                  wr_en,
  input  logic [DATA_W-1:0]     wr_data,
  output logic [DATA_W-1:0]     rd_data,
  input  logic [NUM_PINS-1:0]   pad_in,
  output logic [NUM_PINS-1:0]   pad_out,
  output logic [NUM_PINS-1:0]   pad_oe,
  output logic [NUM_PINS-1:0]   pad_od,
  output logic [NUM_PINS-1:0]   pad_pu,
  output logic [NUM_PINS-1:0]   pad_pd,
  output logic [2*NUM_PINS-1:0] pad_speed
);
  localparam int FIELD_W = 2 * NUM_PINS;

  logic [FIELD_W-1:0]  wr_field;
  logic [FIELD_W-1:0]  mode_q, speed_q, pull_q;
  logic [NUM_PINS-1:0] otype_q, out_q, in_sync;

  assign wr_field = wr_data[FIELD_W-1:0];

  gpio_cfg_regs #(.NUM_PINS(NUM_PINS)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_field(wr_field),
    .mode_q(mode_q), .otype_q(otype_q), .speed_q(speed_q), .pull_q(pull_q)
  );

  gpio_out_reg #(.NUM_PINS(NUM_PINS)) u_out (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_field(wr_field),
    .out_q(out_q)
  );

  gpio_in_sync #(.NUM_PINS(NUM_PINS), .SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw_in(pad_in), .sync_out(in_sync)
  );

  gpio_pin_ctrl #(.NUM_PINS(NUM_PINS)) u_ctrl (
    .mode_q(mode_q), .otype_q(otype_q), .pull_q(pull_q),
    .oe(pad_oe), .od(pad_od), .pu(pad_pu), .pd(pad_pd)
  );

  assign pad_out   = out_q;
  assign pad_speed = speed_q;

  // Read mux; the set/clear word and unused addresses return zero.
  always_comb begin
    rd_data = '0;
    case (addr)
      A_MODE:  rd_data[FIELD_W-1:0]  = mode_q;
      A_OTYPE: rd_data[NUM_PINS-1:0] = otype_q;
      A_SPEED: rd_data[FIELD_W-1:0]  = speed_q;
      A_PULL:  rd_data[FIELD_W-1:0]  = pull_q;
      A_OUT:   rd_data[NUM_PINS-1:0] = out_q;
      A_IN:    rd_data[NUM_PINS-1:0] = in_sync;
      default: ;
    endcase
  end
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
  import gpio_pkg::*;
#(
  parameter int NUM_PINS    = 16,
  parameter int SYNC_STAGES = 2,
  parameter int DATA_W      = 32
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [REG_AW-1:0]     addr,
  input logic                  wr_en,
  input logic [DATA_W-1:0]     wr_data,
  input logic [DATA_W-1:0]     rd_data,
  input logic [NUM_PINS-1:0]   pad_in,
  input logic [NUM_PINS-1:0]   pad_out,
  input logic [NUM_PINS-1:0]   pad_oe,
  input logic [NUM_PINS-1:0]   pad_od,
  input logic [NUM_PINS-1:0]   pad_pu,
  input logic [NUM_PINS-1:0]   pad_pd
);
  logic [1:0] cyc;
  logic       sc_wr, out_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cyc <= '0;
    else if (cyc < 3) cyc <= cyc + 2'd1;
  end

  assign sc_wr  = wr_en && (addr == A_SETCLR);
  assign out_wr = wr_en && (addr == A_OUT);

  // R2
  setclr_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sc_wr |=> ((pad_out & $past(wr_data[NUM_PINS-1:0])) == $past(wr_data[NUM_PINS-1:0])));

  // R3
  setclr_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sc_wr |=> ((pad_out & $past(wr_data[2*NUM_PINS-1:NUM_PINS]) &
                ~$past(wr_data[NUM_PINS-1:0])) == '0));

  // R5
  out_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sc_wr || out_wr) |=> $stable(pad_out));

  // R5
  setclr_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == A_SETCLR) |-> (rd_data == '0));

  // R8
  od_needs_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_od & ~pad_oe) == '0);

  // R9
  pull_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_pu & pad_pd) == '0);

  if (SYNC_STAGES == 2) begin : g_sync2
    // R6
    in_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc >= 2 && addr == A_IN) |-> (rd_data[NUM_PINS-1:0] == $past(pad_in, 2)));
  end
endmodule

bind gpio_port_regs gpio_port_chk #(
  .NUM_PINS(NUM_PINS), .SYNC_STAGES(SYNC_STAGES), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
  .rd_data(rd_data), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
  .pad_od(pad_od), .pad_pu(pad_pu), .pad_pd(pad_pd)
);

// File: tb/sim_gpio_port_regs.sv
module sim_gpio_port_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [15:0] pad_in = '0;
  logic [15:0] pad_out, pad_oe, pad_od, pad_pu, pad_pd;
  logic [31:0] pad_speed;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  gpio_port_regs u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .pad_od(pad_od), .pad_pu(pad_pu), .pad_pd(pad_pd), .pad_speed(pad_speed)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic bus_read(logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rd_data;
  endtask

  task automatic t_reset();
    logic [31:0] r;
    check("R1 pad_out", {16'h0, pad_out}, 32'h0);
    check("R1 pad_oe", {16'h0, pad_oe}, 32'h0);
    check("R1 pad_od/pu/pd", {16'h0, pad_od | pad_pu | pad_pd}, 32'h0);
    check("R1 pad_speed", pad_speed, 32'h0);
    for (int a = 0; a < 5; a++) begin
      bus_read(3'(a), r);
      check("R1 reg zero", r, 32'h0);
    end
  endtask

  task automatic t_setclr();
    logic [31:0] r;
    bus_write(3'd6, 32'h0000_8421);
    check("R2 set bits", {16'h0, pad_out}, 32'h0000_8421);
    bus_write(3'd6, 32'h0000_0010);
    check("R2 zero bits keep", {16'h0, pad_out}, 32'h0000_8431);
    bus_write(3'd6, 32'h8001_0000);
    check("R3 clear pins 15 and 0", {16'h0, pad_out}, 32'h0000_0430);
    bus_read(3'd4, r);
    check("R5 out readback", r, 32'h0000_0430);
    bus_read(3'd6, r);
    check("R5 setclr reads zero", r, 32'h0);
  endtask

  task automatic t_conflict();
    bus_write(3'd6, 32'hFFFF_0000);
    check("R3 clear all", {16'h0, pad_out}, 32'h0);
    bus_write(3'd6, 32'hFFFF_A5A5);
    check("R4 set wins", {16'h0, pad_out}, 32'h0000_A5A5);
  endtask

  task automatic t_out_direct();
    logic [31:0] r;
    bus_write(3'd4, 32'h1234_5A3C);
    check("R5 direct load", {16'h0, pad_out}, 32'h0000_5A3C);
    bus_write(3'd0, 32'h0);
    bus_write(3'd5, 32'hFFFF_FFFF);
    check("R5 other writes hold out", {16'h0, pad_out}, 32'h0000_5A3C);
    bus_read(3'd4, r);
    check("R5 out readback", r, 32'h0000_5A3C);
  endtask

  task automatic t_sync();
    logic [31:0] r;
    @(negedge clk);
    pad_in = 16'hC3A5;
    addr = 3'd5;
    @(negedge clk);
    #1 check("R6 not yet visible after one edge", rd_data, 32'h0);
    @(negedge clk);
    #1 check("R6 visible after two edges", rd_data, 32'h0000_C3A5);
    bus_write(3'd5, 32'h0000_0000);
    bus_read(3'd5, r);
    check("R6 write ignored", r, 32'h0000_C3A5);
  endtask

  task automatic t_open_drain();
    logic [31:0] r;
    bus_write(3'd0, 32'h0000_0040);   // pin 3 output
    bus_write(3'd1, 32'h0000_0008);   // pin 3 open-drain
    bus_write(3'd6, 32'h0000_0008);   // release pin 3 high
    @(negedge clk);
    pad_in = 16'h0000;                // wire held low outside
    repeat (2) @(negedge clk);
    bus_read(3'd5, r);
    check("R6 open-drain reads pad level", r & 32'h8, 32'h0);
    bus_read(3'd4, r);
    check("R6 out word still high", r & 32'h8, 32'h8);
    check("R8 od on output pin", {16'h0, pad_od}, 32'h0000_0008);
  endtask

  task automatic t_mode();
    logic [31:0] r;
    // pins 0..3: in, out, alt, analog; pin 15 out
    bus_write(3'd0, 32'h4000_00E4);
    check("R7 oe only on code 01", {16'h0, pad_oe}, 32'h0000_8002);
    bus_write(3'd1, 32'h0000_800F);
    check("R8 od only where output", {16'h0, pad_od}, 32'h0000_8002);
    bus_read(3'd0, r);
    check("R11 mode readback", r, 32'h4000_00E4);
    bus_read(3'd1, r);
    check("R11 otype readback", r, 32'h0000_800F);
  endtask

  task automatic t_pull();
    logic [31:0] r;
    // pins 0..3: none, up, down, reserved; pin 15 down
    bus_write(3'd3, 32'h8000_00E4);
    check("R9 pull-up", {16'h0, pad_pu}, 32'h0000_0002);
    check("R9 pull-down", {16'h0, pad_pd}, 32'h0000_8004);
    bus_read(3'd3, r);
    check("R11 pull readback", r, 32'h8000_00E4);
  endtask

  task automatic t_speed();
    logic [31:0] r;
    bus_write(3'd2, 32'hC000_001B);
    check("R10 speed codes", pad_speed, 32'hC000_001B);
    bus_read(3'd2, r);
    check("R11 speed readback", r, 32'hC000_001B);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_setclr();
    t_conflict();
    t_out_direct();
    t_sync();
    t_open_drain();
    t_mode();
    t_pull();
    t_speed();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule